// File: doc/BRIEF.md
# Synchronized DMA Request Router Channel

One output channel of a DMA request multiplexer. A programmable selector picks one of `NUM_REQ` peripheral request lines and passes it to a single DMA controller request input. Each high cycle on the selected line counts as one request. In the plain mode every request on the selected line goes straight through. In the gated mode the channel holds requests back until a chosen edge shows up on one of `NUM_SYNC` trigger inputs. It then lets a programmed number of requests through and closes again.

The channel can pulse an event output when a burst finishes. In the plain mode it pulses on every request it passes. If a new trigger edge arrives while a burst is still open, the channel raises a sticky overrun flag. That flag can drive an interrupt line. Software reaches the channel through a small register port with three words: a control word, a status word that this channel shares with its neighbours (it owns bit `CHAN_IDX`), and a flag-clear word where writing a one clears a flag.

Word addresses are 0 for control, 1 for status and 2 for flag clear. The control fields are:

| Bits | Field |
|------|-------|
| [7:0] | request selector |
| [8] | overrun interrupt enable |
| [9] | event enable |
| [16] | gate enable |
| [18:17] | edge select |
| [23:19] | burst length minus one |
| [28:24] | trigger selector |

All other bits read as zero.

Top module: `dma_req_sync_router`

## Requirements
- R1: After reset the control word and status word read zero, and the request output, event output and interrupt output are all low.
- R2: With the gate disabled, the request output follows the line that the request selector picks, in the same cycle. A selector value of `NUM_REQ` or more gives a constant low output.
- R3: With the gate enabled and no burst open, no request reaches the output.
- R4: The edge select chooses what counts as a trigger edge, judged against the trigger line's value in the previous cycle: 2'b01 is rising, 2'b10 is falling, 2'b11 is either edge, and 2'b00 is no edge at all. A trigger selector of `NUM_SYNC` or more never triggers.
- R5: A trigger edge seen while no burst is open opens a burst starting in the next cycle. The burst passes exactly (burst length + 1) requests, from 1 to 32, and then closes.
- R6: A control write leaves the burst-length field unchanged when, before the write, the gate enable or the event enable was set. A burst already open keeps the length that was loaded when it opened.
- R7: With the event enable set, the event output is high for one cycle, in the same cycle as the request that closes a burst. With the gate disabled it is high with every request passed. With the event enable clear it stays low.
- R8: A trigger edge that arrives while a burst is open sets the overrun flag, which reads back at status bit `CHAN_IDX`. That edge does not restart or lengthen the open burst.
- R9: Writing to the flag-clear word with bit `CHAN_IDX` set clears the overrun flag. A write with that bit at zero leaves the flag alone. If a new overrun arrives in the same cycle as a clear, the flag stays set.
- R10: The interrupt output is high exactly while the overrun flag and the overrun interrupt enable are both set.
- R11: Turning the gate enable off discards any open burst. After the gate is turned back on, no request passes until a new trigger edge arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | NUM_REQ | Peripheral request lines |
| sync_in | input | NUM_SYNC | Trigger lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read word address |
| rd_data | output | 32 | Read data, combinational |
| dma_req_o | output | 1 | Request to the DMA controller channel |
| evt_o | output | 1 | Burst completion event pulse |
| irq_o | output | 1 | Overrun interrupt |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the request that closes a burst and a fresh trigger edge. The second pair is a software clear of the overrun flag and a new overrun.

For the first pair, the bench places a second edge on the trigger line while the burst counter is still above zero. It then checks that the overrun flag is set, that the burst still passes exactly its programmed number of requests, and that only one event pulse appears. For the second pair, it issues a clear write in the very cycle a new overrun edge arrives and expects the flag to stay set. A later clear on its own must drop the flag.

Random traffic with random control and clear writes reaches these collisions again and again. Every cycle is compared against a bench model built from the requirements.

// File: rtl/dma_req_sync_router.sv
module dma_req_sync_router #(
  parameter int NUM_REQ  = 16,
  parameter int NUM_SYNC = 8,
  parameter int CHAN_IDX = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REQ-1:0]  req_in,
  input  logic [NUM_SYNC-1:0] sync_in,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [31:0]         wr_data,
  input  logic [1:0]          rd_addr,
  output logic [31:0]         rd_data,
  output logic                dma_req_o,
  output logic                evt_o,
  output logic                irq_o
);
  localparam int RQ_W   = (NUM_REQ  > 1) ? $clog2(NUM_REQ)  : 1;
  localparam int SY_W   = (NUM_SYNC > 1) ? $clog2(NUM_SYNC) : 1;
  localparam int LEN_W  = 5;
  localparam int REM_W  = LEN_W + 1;
  localparam int F_RID  = 0;
  localparam int F_IE   = 8;
  localparam int F_EGE  = 9;
  localparam int F_SE   = 16;
  localparam int F_POL  = 17;
  localparam int F_LEN  = 19;
  localparam int F_SID  = 24;
  localparam logic [7:0] REQ_LIM  = 8'(NUM_REQ);
  localparam logic [4:0] SYNC_LIM = 5'(NUM_SYNC);
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_CLR = 2'd2;

  logic [7:0]          req_id;
  logic                ovr_ie, evt_en, sync_en;
  logic [1:0]          pol;
  logic [LEN_W-1:0]    burst_len;
  logic [4:0]          sync_id;
  logic [NUM_SYNC-1:0] sync_q;
  logic [REM_W-1:0]    remain;
  logic                ovr;

  logic req_sel, sync_now, sync_prev, edge_hit, open_win;
  logic ctrl_wr, clr_wr;
  logic [31:0] ctrl_word;
  logic unused_bits;

  assign unused_bits = ^{wr_data[31:29], wr_data[15:10]};

  assign req_sel   = (req_id  < REQ_LIM)  ? req_in[req_id[RQ_W-1:0]]  : 1'b0;
  assign sync_now  = (sync_id < SYNC_LIM) ? sync_in[sync_id[SY_W-1:0]] : 1'b0;
  assign sync_prev = (sync_id < SYNC_LIM) ? sync_q[sync_id[SY_W-1:0]]  : 1'b0;
  assign edge_hit  = sync_en & ((pol[0] & sync_now & ~sync_prev) |
                                (pol[1] & ~sync_now & sync_prev));
  assign open_win  = (remain != '0);

  assign dma_req_o = req_sel & (~sync_en | open_win);
  assign evt_o     = evt_en & dma_req_o & (~sync_en | (remain == REM_W'(1)));
  assign irq_o     = ovr & ovr_ie;

  assign ctrl_wr = wr_en & (wr_addr == A_CTRL);
  assign clr_wr  = wr_en & (wr_addr == A_CLR) & wr_data[CHAN_IDX];

  always_comb begin
    ctrl_word = '0;
    ctrl_word[F_RID +: 8]     = req_id;
    ctrl_word[F_IE]           = ovr_ie;
    ctrl_word[F_EGE]          = evt_en;
    ctrl_word[F_SE]           = sync_en;
    ctrl_word[F_POL +: 2]     = pol;
    ctrl_word[F_LEN +: LEN_W] = burst_len;
    ctrl_word[F_SID +: 5]     = sync_id;
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = ctrl_word;
      A_STAT:  rd_data = 32'(ovr) << CHAN_IDX;
      default: rd_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_id    <= '0;
      ovr_ie    <= 1'b0;
      evt_en    <= 1'b0;
      sync_en   <= 1'b0;
      pol       <= '0;
      burst_len <= '0;
      sync_id   <= '0;
      sync_q    <= '0;
      remain    <= '0;
      ovr       <= 1'b0;
    end else begin
      sync_q <= sync_in;

      if (ctrl_wr) begin
        req_id  <= wr_data[F_RID +: 8];
        ovr_ie  <= wr_data[F_IE];
        evt_en  <= wr_data[F_EGE];
        sync_en <= wr_data[F_SE];
        pol     <= wr_data[F_POL +: 2];
        sync_id <= wr_data[F_SID +: 5];
        if (!sync_en && !evt_en)
          burst_len <= wr_data[F_LEN +: LEN_W];
      end

      if (!sync_en)
        remain <= '0;
      else if (edge_hit && !open_win)
        remain <= {1'b0, burst_len} + REM_W'(1);
      else if (dma_req_o)
        remain <= remain - REM_W'(1);

      if (edge_hit && open_win)
        ovr <= 1'b1;
      else if (clr_wr)
        ovr <= 1'b0;
    end
  end

  // R3
  closed_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en && !open_win) |-> !dma_req_o);

  // R5
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en && dma_req_o && !ctrl_wr) |=> (remain == $past(remain) - REM_W'(1)));

  // R6
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && (sync_en || evt_en)) |=> $stable(burst_len));

  // R7
  evt_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> dma_req_o);

  // R8
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit && open_win) |=> ovr);

  // R9
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !clr_wr) |=> ovr);
endmodule

// File: tb/dma_req_sync_router_tb.sv
module dma_req_sync_router_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic [15:0] req_in;
  logic [7:0]  sync_in;
  logic        wr_en;
  logic [1:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic        dma_req_o, evt_o, irq_o;

  dma_req_sync_router #(.NUM_REQ(16), .NUM_SYNC(8), .CHAN_IDX(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .sync_in(sync_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .dma_req_o(dma_req_o), .evt_o(evt_o), .irq_o(irq_o));

  int checks = 0, errors = 0, fwd_seen = 0, evt_seen = 0;
  logic [15:0] cur_req;
  logic [7:0]  cur_sync;

  logic [7:0] m_rid; logic m_ie, m_ege, m_se, m_ovr;
  logic [1:0] m_pol; logic [4:0] m_len, m_sid; logic [7:0] m_syncq; int m_rem;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(logic [7:0] rid, logic ie, logic ege, logic se,
                                          logic [1:0] pol, logic [4:0] len, logic [4:0] sid);
    return {3'b0, sid, len, pol, se, 6'b0, ege, ie, rid};
  endfunction

  function automatic logic [31:0] model_ctrl();
    return mk_ctrl(m_rid, m_ie, m_ege, m_se, m_pol, m_len, m_sid);
  endfunction

  task automatic model_reset();
    m_rid = 0; m_ie = 0; m_ege = 0; m_se = 0; m_ovr = 0;
    m_pol = 0; m_len = 0; m_sid = 0; m_syncq = 0; m_rem = 0;
  endtask

  task automatic step(input logic [15:0] rq, input logic [7:0] sy, input logic we,
                      input logic [1:0] wa, input logic [31:0] wd, input logic [1:0] ra);
    logic sel, sn, sp, eg, fwd, ev;
    logic [31:0] rexp;
    @(negedge clk);
    req_in = rq; sync_in = sy; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    cur_req = rq; cur_sync = sy;
    #1;
    sel = (m_rid < 16) ? rq[m_rid[3:0]] : 1'b0;
    sn  = (m_sid < 8) ? sy[m_sid[2:0]] : 1'b0;
    sp  = (m_sid < 8) ? m_syncq[m_sid[2:0]] : 1'b0;
    eg  = m_se && ((m_pol[0] && sn && !sp) || (m_pol[1] && !sn && sp));
    fwd = sel && (!m_se || m_rem > 0);
    ev  = m_ege && fwd && (!m_se || m_rem == 1);
    rexp = (ra == 0) ? model_ctrl() : (ra == 1) ? (32'(m_ovr) << 3) : 32'h0;
    chk(m_se ? "R5" : "R2", 32'(dma_req_o), 32'(fwd));
    chk("R7", 32'(evt_o), 32'(ev));
    chk("R10", 32'(irq_o), 32'(m_ovr && m_ie));
    chk(ra == 1 ? "R8" : "R6", rd_data, rexp);
    if (dma_req_o) fwd_seen++;
    if (evt_o) evt_seen++;
    if (!m_se) m_rem = 0;
    else if (eg && m_rem == 0) m_rem = int'(m_len) + 1;
    else if (fwd) m_rem = m_rem - 1;
    if (eg && m_rem_was_open(eg, sel)) m_ovr = 1'b1;
    else if (we && wa == 2 && wd[3]) m_ovr = 1'b0;
    if (we && wa == 0) begin
      if (!m_se && !m_ege) m_len = wd[23:19];
      m_rid = wd[7:0]; m_ie = wd[8]; m_ege = wd[9]; m_se = wd[16];
      m_pol = wd[18:17]; m_sid = wd[28:24];
    end
    m_syncq = sy;
  endtask

  // Tracks whether a burst was open at the sampled edge (set by pre_open in step ordering)
  logic pre_open;
  function automatic logic m_rem_was_open(logic eg, logic sel);
    return eg && pre_open && (sel || !sel);
  endfunction

  task automatic tick(input logic [15:0] rq, input logic [7:0] sy);
    pre_open = (m_rem > 0);
    step(rq, sy, 1'b0, 2'd0, 32'h0, 2'd1);
  endtask

  task automatic wctrl(input logic [31:0] w);
    pre_open = (m_rem > 0);
    step(cur_req, cur_sync, 1'b1, 2'd0, w, 2'd0);
  endtask

  task automatic wclr(input logic [7:0] sy, input logic [31:0] w);
    pre_open = (m_rem > 0);
    step(cur_req, sy, 1'b1, 2'd2, w, 2'd1);
  endtask

  task automatic edge_count(input logic [1:0] p, input int exp);
    wctrl(mk_ctrl(8'd2, 1'b0, 1'b0, 1'b0, p, 5'd0, 5'd1));
    wctrl(mk_ctrl(8'd2, 1'b0, 1'b0, 1'b1, p, 5'd0, 5'd1));
    fwd_seen = 0;
    for (int i = 0; i < 3; i++) tick(16'h0004, 8'h00);
    for (int i = 0; i < 4; i++) tick(16'h0004, 8'h02);
    for (int i = 0; i < 4; i++) tick(16'h0004, 8'h00);
    chk("R4", 32'(fwd_seen), 32'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_in = 0; sync_in = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    cur_req = 0; cur_sync = 0; pre_open = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    rd_addr = 2'd0; #1;
    chk("R1", rd_data, 32'h0);
    chk("R1", {29'h0, dma_req_o, evt_o, irq_o}, 32'h0);
    rd_addr = 2'd1; #1;
    chk("R1", rd_data, 32'h0);

    // R2 plain routing, including an out-of-range selector
    wctrl(mk_ctrl(8'd5, 1'b0, 1'b0, 1'b0, 2'd0, 5'd0, 5'd0));
    tick(16'h0020, 8'h00); tick(16'h0010, 8'h00); tick(16'hFFDF, 8'h00);
    wctrl(mk_ctrl(8'd200, 1'b0, 1'b0, 1'b0, 2'd0, 5'd0, 5'd0));
    tick(16'hFFFF, 8'h00);
    chk("R2", 32'(dma_req_o), 32'h0);

    // R4 edge select modes
    edge_count(2'd1, 1);
    edge_count(2'd2, 1);
    edge_count(2'd3, 2);
    edge_count(2'd0, 0);

    // R5 and R7: burst of four with one completion event
    wctrl(mk_ctrl(8'd2, 1'b0, 1'b0, 1'b0, 2'd1, 5'd3, 5'd1));
    wctrl(mk_ctrl(8'd2, 1'b0, 1'b1, 1'b1, 2'd1, 5'd3, 5'd1));
    fwd_seen = 0; evt_seen = 0;
    tick(16'h0004, 8'h00);
    tick(16'h0004, 8'h02);
    for (int i = 0; i < 10; i++) tick(16'h0004, 8'h02);
    chk("R5", 32'(fwd_seen), 32'd4);
    chk("R7", 32'(evt_seen), 32'd1);

    // R6 length write ignored while gate or events are enabled
    wctrl(mk_ctrl(8'd2, 1'b0, 1'b1, 1'b1, 2'd1, 5'd9, 5'd1));
    tick(16'h0004, 8'h02);
    rd_addr = 2'd0; #1;
    chk("R6", 32'(rd_data[23:19]), 32'd3);

    // R8 overrun while a burst is open; burst length is not disturbed
    wctrl(mk_ctrl(8'd2, 1'b1, 1'b1, 1'b1, 2'd1, 5'd3, 5'd1));
    tick(16'h0004, 8'h00);
    fwd_seen = 0; evt_seen = 0;
    tick(16'h0004, 8'h02);
    tick(16'h0004, 8'h00);
    tick(16'h0004, 8'h02);
    for (int i = 0; i < 6; i++) tick(16'h0004, 8'h02);
    chk("R8", 32'(fwd_seen), 32'd4);
    chk("R8", 32'(evt_seen), 32'd1);
    chk("R8", rd_data, 32'h8);
    chk("R10", 32'(irq_o), 32'd1);

    // R9 new overrun in the same cycle as a clear: set wins
    tick(16'h0004, 8'h00);
    tick(16'h0004, 8'h02);
    tick(16'h0004, 8'h00);
    wclr(8'h02, 32'h8);
    #1; chk("R9", rd_data, 32'h8);
    wclr(8'h02, 32'hFFFF_FFF7);
    chk("R9", rd_data, 32'h8);
    wclr(8'h02, 32'h8);
    tick(16'h0004, 8'h02);
    chk("R9", rd_data, 32'h0);
    chk("R10", 32'(irq_o), 32'd0);

    // R11 disabling the gate drops an open burst
    for (int i = 0; i < 8; i++) tick(16'h0000, 8'h00);
    tick(16'h0004, 8'h02);
    tick(16'h0004, 8'h02);
    wctrl(mk_ctrl(8'd2, 1'b1, 1'b0, 1'b0, 2'd1, 5'd3, 5'd1));
    wctrl(mk_ctrl(8'd2, 1'b1, 1'b0, 1'b1, 2'd1, 5'd3, 5'd1));
    fwd_seen = 0;
    for (int i = 0; i < 6; i++) tick(16'h0004, 8'h02);
    chk("R11", 32'(fwd_seen), 32'd0);

    // Random traffic with random control and clear writes
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] rq;
      logic [7:0]  sy;
      int r;
      rq = 16'($urandom);
      sy = cur_sync ^ ((($urandom % 3) == 0) ? 8'($urandom) : 8'h00);
      r  = int'($urandom % 40);
      pre_open = (m_rem > 0);
      if (r == 0)
        step(rq, sy, 1'b1, 2'd0,
             mk_ctrl(8'($urandom % 20), 1'($urandom), 1'($urandom), 1'(($urandom % 4) != 0),
                     2'($urandom), 5'($urandom % 6), 5'($urandom % 10)), 2'($urandom % 3));
      else if (r < 4)
        step(rq, sy, 1'b1, 2'd2, 32'($urandom), 2'($urandom % 3));
      else
        step(rq, sy, 1'b0, 2'd0, 32'h0, 2'($urandom % 3));
    end

    @(negedge clk); wr_en = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule